// File: doc/BRIEF.md
# Paged Descriptor Ring Indexer

This block keeps the pointers for three circular descriptor rings that a host and a device share in memory: a request ring (host fills, device drains), a completion ring (device fills) and a message ring (device fills, host drains). A ring is not one contiguous buffer. It is spread over up to `MAX_PAGES` 4 KiB pages, and each page is named by its own page frame number. The block turns a free-running pointer into the byte address of the descriptor slot it points at. It judges whether a request is waiting and whether the message ring has space. It also hands out the index values that the surrounding logic must write back into the shared ring-state area.

Before a configuration command, the surrounding logic loads page frame numbers into a small table for each ring. A data setup command gives the request and completion page counts. A message setup command gives the message page count. On acceptance, the block stores the log2 entry count of each ring, clears that ring's pointers and marks the ring valid. Issuing the memory reads and writes is left to the caller. The caller uses the address outputs, the availability flags and the publish strobes.

Top module: `ringIndexer`

## Requirements
- R1: After reset, `dataValid`, `msgValid`, `setupDone`, `setupErr`, `reqAvail` and `msgRoom` are 0, and all three pointer outputs and all log2 outputs are 0.
- R2: A `dataSetup` with both page counts in 1..`MAX_PAGES` is accepted. On the next cycle `setupDone`=1, `setupErr`=0 and `dataValid`=1. `reqLog2` and `cmpLog2` equal the bit length of (pages × entries-per-page − 1), with 32 request and 128 completion entries per page. `reqConsIdx` and `cmpProdIdx` read 0.
- R3: A `dataSetup` with either count equal to 0 or above `MAX_PAGES` gives `setupDone`=1 and `setupErr`=1 on the next cycle. `dataValid` and the log2 outputs keep their previous values.
- R4: A `msgSetup` is accepted only when its count is in 1..`MAX_PAGES` and `dataValid` is 1. It then sets `msgValid`, sets `msgLog2` (32 entries per page) and zeroes `msgProdIdx`. Otherwise it reports `setupErr`. `msgValid` implies `dataValid`.
- R5: The descriptor address is computed as follows: slot = pointer AND (2^log2 − 1), page = slot / entries-per-page, address = (PFN of that page << 12) + (slot mod entries-per-page) × descriptor size. The descriptor sizes are 128 bytes for requests, 32 for completions and 128 for messages.
- R6: `reqAvail` is 1 only when `dataValid`=1, `reqProdIdx` ≠ `reqConsIdx`, and (`reqProdIdx` − `reqConsIdx`) mod 2^32 < 2^`reqLog2`.
- R7: `reqPop` advances `reqConsIdx` by one on the next edge only when `reqAvail` is 1. Otherwise the pop is ignored.
- R8: `cmpPush` advances `cmpProdIdx` by one whenever `dataValid` is 1, with no fullness check. The slot wraps through the mask while the index keeps counting.
- R9: `msgRoom` is 1 when `msgValid`=1 and (`msgProdShared` − `msgConsShared`) mod 2^32 < 2^`msgLog2`. `msgPush` advances `msgProdIdx` only when `msgRoom` is 1.
- R10: A flush input gives its publish strobe in the same cycle, with the current pointer on the index output, provided the ring is valid. A flush on an invalid ring gives no strobe.
- R11: `adapterReset` clears `dataValid`, `msgValid` and all three pointers on the next edge. Pops and pushes are ignored after that until a new setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| adapterReset | input | 1 | Invalidate all rings and clear pointers |
| pfnWrEn | input | 1 | Write one page frame number |
| pfnWrRing | input | 2 | Target ring: 0 request, 1 completion, 2 message |
| pfnWrIdx | input | PG_W (3) | Page slot in the ring's table |
| pfnWrVal | input | PFN_W (20) | Page frame number |
| dataSetup | input | 1 | Request/completion ring setup command |
| reqPages | input | CNT_W (4) | Request ring page count |
| cmpPages | input | CNT_W (4) | Completion ring page count |
| msgSetup | input | 1 | Message ring setup command |
| msgPages | input | CNT_W (4) | Message ring page count |
| setupDone | output | 1 | Setup command finished (one cycle) |
| setupErr | output | 1 | Setup command rejected (with setupDone) |
| dataValid | output | 1 | Request and completion rings configured |
| msgValid | output | 1 | Message ring configured |
| reqLog2 | output | LOG_W (6) | Request ring log2 entry count |
| cmpLog2 | output | LOG_W (6) | Completion ring log2 entry count |
| msgLog2 | output | LOG_W (6) | Message ring log2 entry count |
| reqProdIdx | input | PTR_W (32) | Host request producer index |
| reqPop | input | 1 | Consume one request descriptor |
| reqAvail | output | 1 | A request descriptor is waiting |
| reqAddr | output | ADDR_W (32) | Address of next request descriptor |
| reqFlush | input | 1 | Publish request consumer index |
| reqPublish | output | 1 | reqConsIdx is to be written back |
| reqConsIdx | output | PTR_W (32) | Request consumer pointer |
| cmpPush | input | 1 | Fill one completion descriptor |
| cmpAddr | output | ADDR_W (32) | Address of next completion slot |
| cmpFlush | input | 1 | Publish completion producer index |
| cmpPublish | output | 1 | cmpProdIdx is to be written back |
| cmpProdIdx | output | PTR_W (32) | Completion producer pointer |
| msgProdShared | input | PTR_W (32) | Message producer index read from memory |
| msgConsShared | input | PTR_W (32) | Message consumer index read from memory |
| msgPush | input | 1 | Fill one message descriptor |
| msgRoom | output | 1 | Message ring has space |
| msgAddr | output | ADDR_W (32) | Address of next message slot |
| msgFlush | input | 1 | Publish message producer index |
| msgPublish | output | 1 | msgProdIdx is to be written back |
| msgProdIdx | output | PTR_W (32) | Message producer pointer |

## Verification
A corrupted pointer shows up on the cycle after the faulty edge, as an address that is off by one descriptor or lands on the wrong page. A wrong mask or log2 value shows up only once a pointer passes a page or ring boundary. The bench therefore drives pointers across the first page edge and past the full ring size. A bad availability compare shows up at once on `reqAvail` or `msgRoom` when the producer-minus-consumer difference is exactly the capacity or wraps below zero. The bench sets up exactly those differences.

// File: rtl/ringIdxPkg.sv
package ringIdxPkg;

  typedef enum logic [1:0] {
    RING_REQ = 2'd0,
    RING_CMP = 2'd1,
    RING_MSG = 2'd2
  } ringSel_e;

  typedef struct packed {
    logic clrData;
    logic clrMsg;
    logic popReq;
    logic pushCmp;
    logic pushMsg;
  } ringStrobe_t;

  // bit length of (pages * 2^eppLog2 - 1)
  function automatic int ringLog2(input int pages, input int eppLog2);
    int lastSlot;
    int n;
    lastSlot = (pages << eppLog2) - 1;
    n = 0;
    for (int i = 0; i < 31; i++) begin
      if ((lastSlot >> i) != 0) n = i + 1;
    end
    return n;
  endfunction

endpackage

// File: rtl/ringCtrl.sv
module ringCtrl
  import ringIdxPkg::*;
#(
  parameter int MAX_PAGES    = 8,
  parameter int CNT_W        = 4,
  parameter int LOG_W        = 6,
  parameter int PTR_W        = 32,
  parameter int REQ_EPP_LOG2 = 5,
  parameter int CMP_EPP_LOG2 = 7,
  parameter int MSG_EPP_LOG2 = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       adapterReset,
  input  logic                       dataSetup,
  input  logic [CNT_W-1:0]           reqPages,
  input  logic [CNT_W-1:0]           cmpPages,
  input  logic                       msgSetup,
  input  logic [CNT_W-1:0]           msgPages,
  input  logic                       reqPop,
  input  logic                       cmpPush,
  input  logic                       msgPush,
  input  logic                       reqFlush,
  input  logic                       cmpFlush,
  input  logic                       msgFlush,
  input  logic                       reqAvailRaw,
  input  logic                       msgRoomRaw,
  output ringStrobe_t                strb,
  output logic                       dataValid,
  output logic                       msgValid,
  output logic [LOG_W-1:0]           reqLog2,
  output logic [LOG_W-1:0]           cmpLog2,
  output logic [LOG_W-1:0]           msgLog2,
  output logic [2:0][PTR_W-1:0]      ringMask,
  output logic                       setupDone,
  output logic                       setupErr,
  output logic                       reqPublish,
  output logic                       cmpPublish,
  output logic                       msgPublish
);

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_PAGES);

  logic reqCntOk, cmpCntOk, msgCntOk, dataOk, msgOk;

  assign reqCntOk = (reqPages != '0) && (reqPages <= MAX_CNT);
  assign cmpCntOk = (cmpPages != '0) && (cmpPages <= MAX_CNT);
  assign msgCntOk = (msgPages != '0) && (msgPages <= MAX_CNT);
  assign dataOk   = reqCntOk && cmpCntOk;
  assign msgOk    = msgCntOk && dataValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataValid <= 1'b0;
      msgValid  <= 1'b0;
      reqLog2   <= '0;
      cmpLog2   <= '0;
      msgLog2   <= '0;
      setupDone <= 1'b0;
      setupErr  <= 1'b0;
    end else begin
      setupDone <= 1'b0;
      setupErr  <= 1'b0;
      if (adapterReset) begin
        dataValid <= 1'b0;
        msgValid  <= 1'b0;
      end else if (dataSetup) begin
        setupDone <= 1'b1;
        if (dataOk) begin
          reqLog2   <= LOG_W'(ringLog2(int'(reqPages), REQ_EPP_LOG2));
          cmpLog2   <= LOG_W'(ringLog2(int'(cmpPages), CMP_EPP_LOG2));
          dataValid <= 1'b1;
        end else begin
          setupErr  <= 1'b1;
        end
      end else if (msgSetup) begin
        setupDone <= 1'b1;
        if (msgOk) begin
          msgLog2  <= LOG_W'(ringLog2(int'(msgPages), MSG_EPP_LOG2));
          msgValid <= 1'b1;
        end else begin
          setupErr <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.clrData = adapterReset || (dataSetup && dataOk);
    strb.clrMsg  = adapterReset || (!dataSetup && msgSetup && msgOk);
    strb.popReq  = reqPop && dataValid && reqAvailRaw;
    strb.pushCmp = cmpPush && dataValid;
    strb.pushMsg = msgPush && msgValid && msgRoomRaw;
  end

  assign ringMask[0] = (PTR_W'(1) << reqLog2) - PTR_W'(1);
  assign ringMask[1] = (PTR_W'(1) << cmpLog2) - PTR_W'(1);
  assign ringMask[2] = (PTR_W'(1) << msgLog2) - PTR_W'(1);

  assign reqPublish = reqFlush && dataValid;
  assign cmpPublish = cmpFlush && dataValid;
  assign msgPublish = msgFlush && msgValid;

endmodule

// File: rtl/ringDatapath.sv
module ringDatapath
  import ringIdxPkg::*;
#(
  parameter int MAX_PAGES  = 8,
  parameter int PG_W       = 3,
  parameter int PFN_W      = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int PTR_W      = 32,
  parameter int ADDR_W     = 32,
  parameter int REQ_DESC   = 128,
  parameter int CMP_DESC   = 32,
  parameter int MSG_DESC   = 128
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ringStrobe_t               strb,
  input  logic [2:0][PTR_W-1:0]     ringMask,
  input  logic                      pfnWrEn,
  input  logic [1:0]                pfnWrRing,
  input  logic [PG_W-1:0]           pfnWrIdx,
  input  logic [PFN_W-1:0]          pfnWrVal,
  input  logic [PTR_W-1:0]          reqProdIdx,
  input  logic [PTR_W-1:0]          msgProdShared,
  input  logic [PTR_W-1:0]          msgConsShared,
  output logic [2:0][PTR_W-1:0]     ringPtr,
  output logic [2:0][ADDR_W-1:0]    ringAddr,
  output logic                      reqAvailRaw,
  output logic                      msgRoomRaw
);

  localparam int PAGE_BYTES = 1 << PAGE_SHIFT;

  for (genvar g = 0; g < 3; g++) begin : gRing
    localparam int DESC      = (g == 0) ? REQ_DESC : ((g == 1) ? CMP_DESC : MSG_DESC);
    localparam int DESC_LOG2 = $clog2(DESC);
    localparam int EPP_LOG2  = $clog2(PAGE_BYTES / DESC);

    logic [PFN_W-1:0]  pfnTab [MAX_PAGES];
    logic              clr;
    logic              adv;
    logic [PTR_W-1:0]  slot;
    logic [PG_W-1:0]   pageIdx;
    logic [ADDR_W-1:0] offset;

    assign clr = (g == 2) ? strb.clrMsg : strb.clrData;
    assign adv = (g == 0) ? strb.popReq : ((g == 1) ? strb.pushCmp : strb.pushMsg);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int p = 0; p < MAX_PAGES; p++) pfnTab[p] <= '0;
      end else if (pfnWrEn && (pfnWrRing == 2'(g))) begin
        pfnTab[pfnWrIdx] <= pfnWrVal;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)     ringPtr[g] <= '0;
      else if (clr)  ringPtr[g] <= '0;
      else if (adv)  ringPtr[g] <= ringPtr[g] + PTR_W'(1);
    end

    assign slot        = ringPtr[g] & ringMask[g];
    assign pageIdx     = PG_W'(slot >> EPP_LOG2);
    assign offset      = ADDR_W'(slot[EPP_LOG2-1:0]) << DESC_LOG2;
    assign ringAddr[g] = {pfnTab[pageIdx], PAGE_SHIFT'(0)} + offset;
  end

  logic [PTR_W-1:0] reqDiff, msgDiff;
  assign reqDiff     = reqProdIdx - ringPtr[0];
  assign msgDiff     = msgProdShared - msgConsShared;
  assign reqAvailRaw = (reqDiff != '0) && (reqDiff < ringMask[0] + PTR_W'(1));
  assign msgRoomRaw  = msgDiff < ringMask[2] + PTR_W'(1);

endmodule

// File: rtl/ringIndexer.sv
module ringIndexer
  import ringIdxPkg::*;
#(
  parameter int MAX_PAGES  = 8,
  parameter int PFN_W      = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int PTR_W      = 32,
  parameter int REQ_DESC   = 128,
  parameter int CMP_DESC   = 32,
  parameter int MSG_DESC   = 128,
  localparam int PG_W      = $clog2(MAX_PAGES),
  localparam int CNT_W     = $clog2(MAX_PAGES + 1),
  localparam int LOG_W     = $clog2(PTR_W) + 1,
  localparam int ADDR_W    = PFN_W + PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              adapterReset,
  input  logic              pfnWrEn,
  input  logic [1:0]        pfnWrRing,
  input  logic [PG_W-1:0]   pfnWrIdx,
  input  logic [PFN_W-1:0]  pfnWrVal,
  input  logic              dataSetup,
  input  logic [CNT_W-1:0]  reqPages,
  input  logic [CNT_W-1:0]  cmpPages,
  input  logic              msgSetup,
  input  logic [CNT_W-1:0]  msgPages,
  output logic              setupDone,
  output logic              setupErr,
  output logic              dataValid,
  output logic              msgValid,
  output logic [LOG_W-1:0]  reqLog2,
  output logic [LOG_W-1:0]  cmpLog2,
  output logic [LOG_W-1:0]  msgLog2,
  input  logic [PTR_W-1:0]  reqProdIdx,
  input  logic              reqPop,
  output logic              reqAvail,
  output logic [ADDR_W-1:0] reqAddr,
  input  logic              reqFlush,
  output logic              reqPublish,
  output logic [PTR_W-1:0]  reqConsIdx,
  input  logic              cmpPush,
  output logic [ADDR_W-1:0] cmpAddr,
  input  logic              cmpFlush,
  output logic              cmpPublish,
  output logic [PTR_W-1:0]  cmpProdIdx,
  input  logic [PTR_W-1:0]  msgProdShared,
  input  logic [PTR_W-1:0]  msgConsShared,
  input  logic              msgPush,
  output logic              msgRoom,
  output logic [ADDR_W-1:0] msgAddr,
  input  logic              msgFlush,
  output logic              msgPublish,
  output logic [PTR_W-1:0]  msgProdIdx
);

  localparam int PAGE_BYTES = 1 << PAGE_SHIFT;

  ringStrobe_t             strb;
  logic [2:0][PTR_W-1:0]   ringMask;
  logic [2:0][PTR_W-1:0]   ringPtr;
  logic [2:0][ADDR_W-1:0]  ringAddr;
  logic                    reqAvailRaw, msgRoomRaw;

  ringCtrl #(
    .MAX_PAGES    (MAX_PAGES),
    .CNT_W        (CNT_W),
    .LOG_W        (LOG_W),
    .PTR_W        (PTR_W),
    .REQ_EPP_LOG2 ($clog2(PAGE_BYTES / REQ_DESC)),
    .CMP_EPP_LOG2 ($clog2(PAGE_BYTES / CMP_DESC)),
    .MSG_EPP_LOG2 ($clog2(PAGE_BYTES / MSG_DESC))
  ) u_ctrl (
    .clk, .rstN, .adapterReset,
    .dataSetup, .reqPages, .cmpPages, .msgSetup, .msgPages,
    .reqPop, .cmpPush, .msgPush, .reqFlush, .cmpFlush, .msgFlush,
    .reqAvailRaw, .msgRoomRaw,
    .strb, .dataValid, .msgValid, .reqLog2, .cmpLog2, .msgLog2, .ringMask,
    .setupDone, .setupErr, .reqPublish, .cmpPublish, .msgPublish
  );

  ringDatapath #(
    .MAX_PAGES  (MAX_PAGES),
    .PG_W       (PG_W),
    .PFN_W      (PFN_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .PTR_W      (PTR_W),
    .ADDR_W     (ADDR_W),
    .REQ_DESC   (REQ_DESC),
    .CMP_DESC   (CMP_DESC),
    .MSG_DESC   (MSG_DESC)
  ) u_dp (
    .clk, .rstN, .strb, .ringMask,
    .pfnWrEn, .pfnWrRing, .pfnWrIdx, .pfnWrVal,
    .reqProdIdx, .msgProdShared, .msgConsShared,
    .ringPtr, .ringAddr, .reqAvailRaw, .msgRoomRaw
  );

  assign reqAvail   = reqAvailRaw && dataValid;
  assign msgRoom    = msgRoomRaw && msgValid;
  assign reqConsIdx = ringPtr[0];
  assign cmpProdIdx = ringPtr[1];
  assign msgProdIdx = ringPtr[2];
  assign reqAddr    = ringAddr[0];
  assign cmpAddr    = ringAddr[1];
  assign msgAddr    = ringAddr[2];

endmodule

// File: rtl/ringIndexer_chk.sv
module ringIndexer_chk #(
  parameter int PTR_W    = 32,
  parameter int ADDR_W   = 32,
  parameter int REQ_DESC = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              adapterReset,
  input logic              dataSetup,
  input logic              reqPop,
  input logic              reqAvail,
  input logic [PTR_W-1:0]  reqConsIdx,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              cmpPush,
  input logic [PTR_W-1:0]  cmpProdIdx,
  input logic              dataValid,
  input logic              msgValid,
  input logic              setupDone,
  input logic              setupErr
);

  AST_POP_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    (reqPop && reqAvail && !dataSetup && !adapterReset) |=> (reqConsIdx == $past(reqConsIdx) + PTR_W'(1))); // R7
  AST_NO_POP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (!reqAvail && !dataSetup && !adapterReset) |=> (reqConsIdx == $past(reqConsIdx))); // R7
  AST_AVAIL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |-> !reqAvail); // R6
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    setupErr |-> setupDone); // R3
  AST_MSG_AFTER_DATA: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> dataValid); // R4
  AST_RESET_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    adapterReset |=> (!dataValid && !msgValid)); // R11
  AST_REQ_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (reqAddr & ADDR_W'(REQ_DESC - 1)) == '0); // R5
  AST_CMP_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    (cmpPush && dataValid && !dataSetup && !adapterReset) |=> (cmpProdIdx == $past(cmpProdIdx) + PTR_W'(1))); // R8

endmodule

bind ringIndexer ringIndexer_chk #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .REQ_DESC(REQ_DESC)) u_chk (.*);

// File: tb/ringIndexer_tb.sv
`timescale 1ns/1ps
module ringIndexer_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic adapterReset = 0, pfnWrEn = 0, dataSetup = 0, msgSetup = 0;
  logic [1:0] pfnWrRing = 0;
  logic [2:0] pfnWrIdx = 0;
  logic [19:0] pfnWrVal = 0;
  logic [3:0] reqPages = 0, cmpPages = 0, msgPages = 0;
  logic setupDone, setupErr, dataValid, msgValid;
  logic [5:0] reqLog2, cmpLog2, msgLog2;
  logic [31:0] reqProdIdx = 0, msgProdShared = 0, msgConsShared = 0;
  logic reqPop = 0, reqFlush = 0, cmpPush = 0, cmpFlush = 0, msgPush = 0, msgFlush = 0;
  logic reqAvail, reqPublish, cmpPublish, msgRoom, msgPublish;
  logic [31:0] reqAddr, cmpAddr, msgAddr, reqConsIdx, cmpProdIdx, msgProdIdx;

  ringIndexer u_dut (.*);

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int blen(input int x);
    int n = 0;
    while ((x >> n) != 0) n++;
    return n;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic loadPfn(input int ring, input int idx, input int val);
    pfnWrEn = 1; pfnWrRing = 2'(ring); pfnWrIdx = 3'(idx); pfnWrVal = 20'(val);
    step();
    pfnWrEn = 0;
  endtask

  task automatic doDataSetup(input int rp, input int cp);
    reqPages = 4'(rp); cmpPages = 4'(cp); dataSetup = 1;
    step();
    dataSetup = 0;
  endtask

  task automatic doMsgSetup(input int mp);
    msgPages = 4'(mp); msgSetup = 1;
    step();
    msgSetup = 0;
  endtask

  task automatic testReset();
    chk("R1 dataValid", 32'(dataValid), 0);
    chk("R1 msgValid", 32'(msgValid), 0);
    chk("R1 setupDone", 32'(setupDone), 0);
    chk("R1 reqAvail", 32'(reqAvail), 0);
    chk("R1 msgRoom", 32'(msgRoom), 0);
    chk("R1 ptrs", reqConsIdx | cmpProdIdx | msgProdIdx, 0);
    chk("R1 log2", 32'(reqLog2) | 32'(cmpLog2) | 32'(msgLog2), 0);
  endtask

  task automatic testBadSetup();
    doMsgSetup(1);
    chk("R4 msg before data err", 32'(setupErr), 1);
    chk("R4 msgValid stays", 32'(msgValid), 0);
    doDataSetup(0, 1);
    chk("R3 zero pages done", 32'(setupDone), 1);
    chk("R3 zero pages err", 32'(setupErr), 1);
    doDataSetup(1, 9);
    chk("R3 too many pages err", 32'(setupErr), 1);
    chk("R3 dataValid stays", 32'(dataValid), 0);
  endtask

  task automatic testGoodSetup();
    doDataSetup(2, 1);
    chk("R2 done", 32'(setupDone), 1);
    chk("R2 no err", 32'(setupErr), 0);
    chk("R2 dataValid", 32'(dataValid), 1);
    chk("R2 reqLog2", 32'(reqLog2), 32'(blen(2 * 32 - 1)));
    chk("R2 cmpLog2", 32'(cmpLog2), 32'(blen(1 * 128 - 1)));
    chk("R2 ptrs zero", reqConsIdx | cmpProdIdx, 0);
  endtask

  task automatic testReqRing();
    reqProdIdx = 0; #1;
    chk("R6 empty", 32'(reqAvail), 0);
    reqPop = 1; step(); reqPop = 0;
    chk("R7 pop ignored", reqConsIdx, 0);
    reqProdIdx = 3; #1;
    chk("R6 avail", 32'(reqAvail), 1);
    chk("R5 req slot0", reqAddr, 32'h0010_0000);
    reqPop = 1; step();
    chk("R5 req slot1", reqAddr, 32'h0010_0080);
    step();
    chk("R5 req slot2", reqAddr, 32'h0010_0100);
    step(); reqPop = 0;
    chk("R7 cons 3", reqConsIdx, 3);
    chk("R6 drained", 32'(reqAvail), 0);
    reqProdIdx = 43;
    reqPop = 1; repeat (29) step(); reqPop = 0;
    chk("R7 cons 32", reqConsIdx, 32);
    chk("R5 page cross", reqAddr, 32'h0010_1000);
    reqProdIdx = 32 + 64; #1;
    chk("R6 capacity full", 32'(reqAvail), 0);
    reqProdIdx = 32 + 63; #1;
    chk("R6 below capacity", 32'(reqAvail), 1);
    reqProdIdx = 31; #1;
    chk("R6 wrap-safe negative diff", 32'(reqAvail), 0);
    reqProdIdx = 70;
    reqPop = 1; repeat (32) step(); reqPop = 0;
    chk("R7 cons 64", reqConsIdx, 64);
    chk("R5 ring wrap slot", reqAddr, 32'h0010_0000);
    reqFlush = 1; #1;
    chk("R10 req publish", 32'(reqPublish), 1);
    chk("R10 req value", reqConsIdx, 64);
    step(); reqFlush = 0;
  endtask

  task automatic testCmpRing();
    chk("R5 cmp slot0", cmpAddr, 32'h0020_0000);
    cmpPush = 1; repeat (5) step();
    chk("R8 cmp idx 5", cmpProdIdx, 5);
    chk("R5 cmp slot5", cmpAddr, 32'h0020_00A0);
    repeat (123) step(); cmpPush = 0;
    chk("R8 cmp no overflow check", cmpProdIdx, 128);
    chk("R8 cmp slot wraps", cmpAddr, 32'h0020_0000);
    cmpFlush = 1; #1;
    chk("R10 cmp publish", 32'(cmpPublish), 1);
    chk("R10 cmp value", cmpProdIdx, 128);
    step(); cmpFlush = 0;
  endtask

  task automatic testMsgRing();
    doMsgSetup(0);
    chk("R4 msg zero err", 32'(setupErr), 1);
    doMsgSetup(9);
    chk("R4 msg large err", 32'(setupErr), 1);
    chk("R4 msgValid off", 32'(msgValid), 0);
    doMsgSetup(1);
    chk("R4 msg ok", 32'(setupErr), 0);
    chk("R4 msgValid", 32'(msgValid), 1);
    chk("R4 msgLog2", 32'(msgLog2), 32'(blen(31)));
    msgProdShared = 32; msgConsShared = 0; #1;
    chk("R9 full", 32'(msgRoom), 0);
    msgPush = 1; step(); msgPush = 0;
    chk("R9 push ignored", msgProdIdx, 0);
    msgProdShared = 5; #1;
    chk("R9 room", 32'(msgRoom), 1);
    chk("R5 msg slot0", msgAddr, 32'h0030_0000);
    msgPush = 1; step(); msgPush = 0;
    chk("R9 push", msgProdIdx, 1);
    chk("R5 msg slot1", msgAddr, 32'h0030_0080);
    msgFlush = 1; #1;
    chk("R10 msg publish", 32'(msgPublish), 1);
    step(); msgFlush = 0;
  endtask

  task automatic testAdapterReset();
    adapterReset = 1; step(); adapterReset = 0;
    chk("R11 dataValid", 32'(dataValid), 0);
    chk("R11 msgValid", 32'(msgValid), 0);
    chk("R11 ptrs", reqConsIdx | cmpProdIdx | msgProdIdx, 0);
    chk("R11 reqAvail", 32'(reqAvail), 0);
    cmpPush = 1; step(); cmpPush = 0;
    chk("R11 push ignored", cmpProdIdx, 0);
    reqFlush = 1; #1;
    chk("R10 no publish when invalid", 32'(reqPublish), 0);
    step(); reqFlush = 0;
  endtask

  task automatic testResetup();
    doDataSetup(3, 8);
    chk("R2 reqLog2 3 pages", 32'(reqLog2), 32'(blen(3 * 32 - 1)));
    chk("R2 cmpLog2 8 pages", 32'(cmpLog2), 32'(blen(8 * 128 - 1)));
    doDataSetup(9, 1);
    chk("R3 err keeps valid", 32'(dataValid), 1);
    chk("R3 err keeps log2", 32'(reqLog2), 32'(blen(95)));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    loadPfn(0, 0, 'h100); loadPfn(0, 1, 'h101);
    loadPfn(1, 0, 'h200);
    loadPfn(2, 0, 'h300);
    testBadSetup();
    testGoodSetup();
    testReqRing();
    testCmpRing();
    testMsgRing();
    testAdapterReset();
    testResetup();
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule